// File: doc/BRIEF.md
# Split-Port Burst-of-Four DDR SRAM

This block is a synthesizable model of a synchronous static memory that has one write data bus and one read data bus, with a single address bus shared between them. A read command and a write command can both be issued on the same rising edge of `k`. Each address names a group of four words. The four words of a group move as one burst at double data rate: two words per clock cycle on each port. Because the two data buses never turn around, a host can stream reads and writes at the same time.

The read address and the read select are captured on a rising edge of `k`. The write select is also captured on a rising edge of `k`. The write address follows on the next rising edge of `k_n`. Write words are taken on the four rising edges of `k` and `k_n` that come after that. Read words leave through output registers clocked by `c` and `c_n`. Each read word is marked by `q_valid`. The model expects `c` in phase with `k`, and `c_n` and `k_n` to be the inverses of those clocks. The storage depth is set by `GROUP_BITS`, which keeps the model small.

Top module: `sio_burst_sram`

## Requirements
- R1: When `rps_n` is low at a rising edge of `k`, that edge captures the group address. The four words of the group, index 0, 1, 2, 3 in that order, are launched on the next-but-one rising edge of `c_n` (1.5 cycles after the command), then the following `c`, `c_n` and `c` rising edges. `q_valid` is high for exactly those four half-cycles.
- R2: When `wps_n` is low at a rising edge of `k`, the group address is taken from `addr` at the next rising edge of `k_n`. The words with index 0, 1, 2, 3 are then taken from `d` on the four rising edges that follow: `k`, `k_n`, `k`, `k_n`.
- R3: Every write word has its own lane enables, sampled with that word. A low `bws_n[0]` stores bits 8:0 and a low `bws_n[1]` stores bits 17:9. A lane whose enable is high keeps its previous contents.
- R4: A read command and a write command may be given on the same rising edge of `k`. Neither one disturbs the timing or the data of the other.
- R5: A read whose command edge is the same as, or later than, the write-select edge of a write burst to the same group returns the newly written words. A read issued one cycle before that write-select edge returns the contents from before the write.
- R6: While a select is high, nothing on `addr`, `d` or `bws_n` changes the storage or starts a read burst on that port.
- R7: When no read word is being launched, `q` keeps the last value it showed and `q_valid` is low.
- R8: A new command on each port may come at most every other rising edge of `k`. At exactly that rate, consecutive read bursts join with no gap in `q_valid`.
- R9: Only `addr[GROUP_BITS-1:0]` selects the group. Addresses that differ only above those bits reach the same storage.
- R10: While `rst_n` is low, and directly after it is released, `q_valid` is low and `q` is zero. The stored data is not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| k | input | 1 | Input clock; captures commands, the read address and even-index write words |
| k_n | input | 1 | Inverse input clock; captures the write address and odd-index write words |
| c | input | 1 | Output clock in phase with `k`; launches odd-index read words |
| c_n | input | 1 | Inverse output clock; launches even-index read words |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| rps_n | input | 1 | Active-low read select |
| wps_n | input | 1 | Active-low write select |
| bws_n | input | 2 | Active-low lane enables for the current write word |
| addr | input | 18 | Shared group address bus |
| d | input | 18 | Write data |
| q | output | 18 | Read data |
| q_valid | output | 1 | High while `q` carries a read burst word |

## Verification
Words are stored in two banks, split by even and odd word index. A fault in the phase flag or the group register therefore shows up on `q` as swapped or foreign words inside a single burst. It appears within 1.5 to 3 cycles of the read command. A wrong write-sequence flag damages a stored group that is invisible until that group is read back, so every group is read after each write phase and again after a long stretch of ignored noise. A read/write ordering fault shows as stale or early data in the reads placed exactly on, and one cycle before, a write select to the same group.

// File: rtl/sio_pkg.sv
package sio_pkg;
    localparam int ADDR_W = 18;
    localparam int WORD_W = 18;
    localparam int LANES  = 2;
    localparam int LANE_W = WORD_W / LANES;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  lane_n_t;

    // Replace each lane whose active-low enable is asserted.
    function automatic word_t lane_merge(word_t old_w, word_t new_w, lane_n_t en_n);
        word_t r;
        for (int l = 0; l < LANES; l++) begin
            r[l*LANE_W +: LANE_W] = en_n[l] ? old_w[l*LANE_W +: LANE_W]
                                            : new_w[l*LANE_W +: LANE_W];
        end
        return r;
    endfunction
endpackage

// File: rtl/sio_bank.sv
module sio_bank
    import sio_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] w_idx,
    input  word_t            w_data,
    input  lane_n_t          w_lane_n,
    input  logic [IDX_W-1:0] r_idx,
    output word_t            r_data
);
    localparam int DEPTH = 1 << IDX_W;

    word_t mem_q [DEPTH];

    // Written on its own clock edge only; read half a cycle away from it.
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[w_idx] <= lane_merge(mem_q[w_idx], w_data, w_lane_n);
        end
    end

    assign r_data = mem_q[r_idx];
endmodule

// File: rtl/sio_wr_front.sv
module sio_wr_front #(
    parameter int GB = 4
) (
    input  logic          k,
    input  logic          k_n,
    input  logic          rst_n,
    input  logic          wps_n,
    input  logic [GB-1:0] grp_in,
    output logic          ev_we,
    output logic [GB:0]   ev_idx,
    output logic          od_we,
    output logic [GB:0]   od_idx
);
    typedef struct packed {
        logic cmd;    // write select seen on this k edge
        logic w2;     // word 0 stored, word 2 due next k edge
        logic ev_v;   // an even word was stored on this k edge
        logic ev_ph;  // 0: word 0, 1: word 2
    } kst_t;

    typedef struct packed {
        logic          start;  // address captured, word 0 due next k edge
        logic [GB-1:0] grp;
    } nst_t;

    kst_t k_d, k_q;
    nst_t n_d, n_q;

    // k domain: command capture and even-word sequencing
    always_comb begin
        k_d       = k_q;
        k_d.cmd   = ~wps_n;
        k_d.w2    = n_q.start;
        k_d.ev_v  = n_q.start | k_q.w2;
        k_d.ev_ph = k_q.w2;
    end

    always_ff @(posedge k or negedge rst_n) begin
        if (!rst_n) k_q <= '0;
        else        k_q <= k_d;
    end

    // k_n domain: address capture
    always_comb begin
        n_d       = n_q;
        n_d.start = k_q.cmd;
        if (k_q.cmd) n_d.grp = grp_in;
    end

    always_ff @(posedge k_n or negedge rst_n) begin
        if (!rst_n) n_q <= '0;
        else        n_q <= n_d;
    end

    assign ev_we  = n_q.start | k_q.w2;
    assign ev_idx = {n_q.grp, k_q.w2};
    assign od_we  = k_q.ev_v;
    assign od_idx = {n_q.grp, k_q.ev_ph};

    p_wr_spacing_r8: assert property (@(posedge k) disable iff (!rst_n)
        k_q.cmd |-> wps_n);

    p_wr_slot_r2: assert property (@(posedge k) disable iff (!rst_n)
        !(n_q.start && k_q.w2));
endmodule

// File: rtl/sio_rd_path.sv
module sio_rd_path
    import sio_pkg::*;
#(
    parameter int GB = 4
) (
    input  logic          k,
    input  logic          c,
    input  logic          c_n,
    input  logic          rst_n,
    input  logic          rps_n,
    input  logic [GB-1:0] grp_in,
    output logic [GB:0]   ev_idx,
    input  word_t         ev_data,
    output logic [GB:0]   od_idx,
    input  word_t         od_data,
    output word_t         q,
    output logic          q_valid
);
    typedef struct packed {
        logic          cmd;
        logic [GB-1:0] grp;
    } rk_t;

    typedef struct packed {
        logic          s1;   // word 0 due on next c_n edge
        logic          s2;   // word 2 due on next c_n edge
        logic [GB-1:0] g1;
        logic [GB-1:0] g2;
        logic          v;    // even word launched on last c_n edge
        logic          ph;   // 0: word 0, 1: word 2
        logic [GB-1:0] lg;   // group of the launched word
        word_t         q;
    } rn_t;

    typedef struct packed {
        logic  v;
        word_t q;
    } rc_t;

    rk_t rk_d, rk_q;
    rn_t rn_d, rn_q;
    rc_t rc_d, rc_q;

    // k domain: read command capture
    always_comb begin
        rk_d     = rk_q;
        rk_d.cmd = ~rps_n;
        if (!rps_n) rk_d.grp = grp_in;
    end

    always_ff @(posedge k or negedge rst_n) begin
        if (!rst_n) rk_q <= '0;
        else        rk_q <= rk_d;
    end

    // c_n domain: launch words 0 and 2
    assign ev_idx = rn_q.s2 ? {rn_q.g2, 1'b1} : {rn_q.g1, 1'b0};

    always_comb begin
        rn_d    = rn_q;
        rn_d.s1 = rk_q.cmd;
        if (rk_q.cmd) rn_d.g1 = rk_q.grp;
        rn_d.s2 = rn_q.s1;
        if (rn_q.s1) rn_d.g2 = rn_q.g1;
        rn_d.v  = rn_q.s1 | rn_q.s2;
        rn_d.ph = rn_q.s2;
        rn_d.lg = rn_q.s2 ? rn_q.g2 : rn_q.g1;
        rn_d.q  = (rn_q.s1 | rn_q.s2) ? ev_data : rc_q.q;
    end

    always_ff @(posedge c_n or negedge rst_n) begin
        if (!rst_n) rn_q <= '0;
        else        rn_q <= rn_d;
    end

    // c domain: launch words 1 and 3 right after their even partner
    assign od_idx = {rn_q.lg, rn_q.ph};

    always_comb begin
        rc_d   = rc_q;
        rc_d.v = rn_q.v;
        rc_d.q = rn_q.v ? od_data : rn_q.q;
    end

    always_ff @(posedge c or negedge rst_n) begin
        if (!rst_n) rc_q <= '0;
        else        rc_q <= rc_d;
    end

    assign q       = c ? rc_q.q : rn_q.q;
    assign q_valid = c ? rc_q.v : rn_q.v;

    p_rd_spacing_r8: assert property (@(posedge k) disable iff (!rst_n)
        rk_q.cmd |-> rps_n);

    p_even_slot_r8: assert property (@(posedge c_n) disable iff (!rst_n)
        !(rn_q.s1 && rn_q.s2));

    p_word_order_r1: assert property (@(posedge c_n) disable iff (!rst_n)
        (rn_q.v && !rn_q.ph) |=> (rn_q.v && rn_q.ph));
endmodule

// File: rtl/sio_burst_sram.sv
module sio_burst_sram
    import sio_pkg::*;
#(
    parameter int GROUP_BITS = 4
) (
    input  logic              k,
    input  logic              k_n,
    input  logic              c,
    input  logic              c_n,
    input  logic              rst_n,
    input  logic              rps_n,
    input  logic              wps_n,
    input  logic [LANES-1:0]  bws_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] d,
    output logic [WORD_W-1:0] q,
    output logic              q_valid
);
    localparam int IDX_W = GROUP_BITS + 1;

    logic [1:0]       b_clk;
    logic             b_we    [2];
    logic [IDX_W-1:0] b_widx  [2];
    logic [IDX_W-1:0] b_ridx  [2];
    word_t            b_rdata [2];

    // bank 0 holds words 0 and 2 (k edges), bank 1 words 1 and 3 (k_n edges)
    assign b_clk = {k_n, k};

    sio_wr_front #(.GB(GROUP_BITS)) u_wr (
        .k      (k),
        .k_n    (k_n),
        .rst_n  (rst_n),
        .wps_n  (wps_n),
        .grp_in (addr[GROUP_BITS-1:0]),
        .ev_we  (b_we[0]),
        .ev_idx (b_widx[0]),
        .od_we  (b_we[1]),
        .od_idx (b_widx[1])
    );

    sio_rd_path #(.GB(GROUP_BITS)) u_rd (
        .k       (k),
        .c       (c),
        .c_n     (c_n),
        .rst_n   (rst_n),
        .rps_n   (rps_n),
        .grp_in  (addr[GROUP_BITS-1:0]),
        .ev_idx  (b_ridx[0]),
        .ev_data (b_rdata[0]),
        .od_idx  (b_ridx[1]),
        .od_data (b_rdata[1]),
        .q       (q),
        .q_valid (q_valid)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        sio_bank #(.IDX_W(IDX_W)) u_bank (
            .clk      (b_clk[b]),
            .we       (b_we[b]),
            .w_idx    (b_widx[b]),
            .w_data   (d),
            .w_lane_n (bws_n),
            .r_idx    (b_ridx[b]),
            .r_data   (b_rdata[b])
        );
    end

    p_rd_addr_known_r1: assert property (@(posedge k) disable iff (!rst_n)
        !rps_n |-> !$isunknown(addr));
endmodule

// File: tb/test_sio_burst_sram.sv
module test_sio_burst_sram;
    localparam int CLK_PERIOD = 10;
    localparam int GB   = 4;
    localparam int NGRP = 1 << GB;
    localparam int NH   = 404;

    logic k = 1'b0;
    logic k_n, c, c_n, rst_n;
    logic rps_n, wps_n;
    logic [1:0]  bws_n;
    logic [17:0] addr, d, q;
    logic q_valid;

    assign k_n = ~k;
    assign c   = k;
    assign c_n = ~k;
    always #(CLK_PERIOD/2) k = ~k;

    sio_burst_sram #(.GROUP_BITS(GB)) i_sio_burst_sram (
        .k(k), .k_n(k_n), .c(c), .c_n(c_n), .rst_n(rst_n),
        .rps_n(rps_n), .wps_n(wps_n), .bws_n(bws_n),
        .addr(addr), .d(d), .q(q), .q_valid(q_valid)
    );

    // stimulus per half-cycle edge (even h: k rise, odd h: k_n rise)
    logic        s_rps [NH];
    logic        s_wps [NH];
    logic [17:0] s_addr[NH];
    logic [17:0] s_d   [NH];
    logic [1:0]  s_bw  [NH];
    logic        rl_v  [NH];
    int          rl_idx[NH];
    string       rl_tag[NH];
    logic        wl_v  [NH];
    int          wl_idx[NH];
    logic [17:0] exp_q [NH];
    logic        exp_v [NH];
    string       exp_tag[NH];
    logic [17:0] mdl [NGRP*4];

    int nchk  = 0;
    int nfail = 0;

    function automatic logic [17:0] wword(int seed, int i);
        return 18'(seed * 1103 + i * 2741 + 91);
    endfunction

    task automatic sched_write(int hk, logic [17:0] a, int seed, logic [7:0] masks);
        s_wps[hk]     = 1'b0;
        s_addr[hk+1]  = a;
        for (int i = 0; i < 4; i++) begin
            s_d[hk+2+i]    = wword(seed, i);
            s_bw[hk+2+i]   = masks[2*i +: 2];
            wl_v[hk+2+i]   = 1'b1;
            wl_idx[hk+2+i] = int'(a[GB-1:0]) * 4 + i;
        end
    endtask

    task automatic sched_read(int hk, logic [17:0] a, string tag);
        s_rps[hk]  = 1'b0;
        s_addr[hk] = a;
        for (int i = 0; i < 4; i++) begin
            rl_v[hk+3+i]   = 1'b1;
            rl_idx[hk+3+i] = int'(a[GB-1:0]) * 4 + i;
            rl_tag[hk+3+i] = tag;
        end
    endtask

    task automatic chk(bit ok, string tag, logic [17:0] act, logic [17:0] expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, expv, $time);
        end
    endtask

    initial begin
        #(CLK_PERIOD*5000);
        nfail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        logic [17:0] prev;
        // idle noise: selects high, lanes enabled, bus busy (R6)
        for (int h = 0; h < NH; h++) begin
            s_rps[h]  = 1'b1;
            s_wps[h]  = 1'b1;
            s_addr[h] = 18'(h * 677 + 3);
            s_d[h]    = 18'(h * 929 + 17);
            s_bw[h]   = 2'b00;
            rl_v[h]   = 1'b0;
            rl_idx[h] = 0;
            rl_tag[h] = "";
            wl_v[h]   = 1'b0;
            wl_idx[h] = 0;
        end
        for (int g = 0; g < NGRP*4; g++) mdl[g] = '0;

        // fill every group back to back
        for (int g = 0; g < NGRP; g++) sched_write(4*g, 18'(g), g + 1, 8'h00);
        // seamless read sweep
        for (int g = 0; g < NGRP; g++)
            sched_read(72 + 4*g, 18'(g), (g == 0) ? "R1" : ((g < 8) ? "R2" : "R8"));
        // lane enables: word0 lane0 off, word1 lane1 off, word2 both, word3 none (R3)
        sched_write(144, 18'd3, 100, 8'b11_00_10_01);
        // alias through upper address bits (R9)
        sched_write(152, (18'h155 << GB) | 18'd9, 110, 8'h00);
        sched_read(164, 18'd3, "R3");
        sched_read(168, (18'h2aa << GB) | 18'd9, "R9");
        // ordering between ports on one group (R5)
        sched_write(180, 18'd5, 200, 8'h00);
        sched_read(180, 18'd5, "R5");
        sched_read(190, 18'd6, "R5");
        sched_write(192, 18'd6, 201, 8'h00);
        sched_read(200, 18'd6, "R5");
        // concurrent mixed traffic (R4)
        for (int j = 0; j < 20; j++) begin
            sched_write(212 + 4*j, 18'((5*j + 1) % NGRP) | (18'(j) << GB), 300 + j, 8'h00);
            sched_read(214 + 4*j, 18'((3*j) % NGRP) | (18'(j + 7) << GB), "R4");
        end
        // after a long ignored stretch, every group must be intact (R6)
        for (int g = 0; g < NGRP; g++) sched_read(332 + 4*g, 18'(g), "R6");

        // reference: launches see every word stored on an earlier edge
        prev = '0;
        for (int h = 0; h < NH; h++) begin
            if (rl_v[h]) begin
                exp_q[h]   = mdl[rl_idx[h]];
                exp_v[h]   = 1'b1;
                exp_tag[h] = rl_tag[h];
            end else begin
                exp_q[h]   = prev;
                exp_v[h]   = 1'b0;
                exp_tag[h] = "R7";
            end
            prev = exp_q[h];
            if (wl_v[h]) begin
                if (!s_bw[h][0]) mdl[wl_idx[h]][8:0]  = s_d[h][8:0];
                if (!s_bw[h][1]) mdl[wl_idx[h]][17:9] = s_d[h][17:9];
            end
        end

        rst_n = 1'b0; rps_n = 1'b1; wps_n = 1'b1; bws_n = 2'b11; addr = '0; d = '0;
        repeat (3) @(posedge k);
        #2;
        chk(q_valid == 1'b0, "R10", {17'd0, q_valid}, 18'd0);
        chk(q == 18'd0, "R10", q, 18'd0);
        @(posedge k_n);
        #2;
        rst_n = 1'b1;
        chk(q_valid == 1'b0, "R10", {17'd0, q_valid}, 18'd0);
        chk(q == 18'd0, "R10", q, 18'd0);

        for (int h = 0; h < NH; h++) begin
            rps_n = s_rps[h];
            wps_n = s_wps[h];
            addr  = s_addr[h];
            d     = s_d[h];
            bws_n = s_bw[h];
            if (h % 2 == 0) @(posedge k);
            else            @(posedge k_n);
            #2;
            chk(q_valid == exp_v[h], exp_tag[h], {17'd0, q_valid}, {17'd0, exp_v[h]});
            chk(q == exp_q[h], exp_tag[h], q, exp_q[h]);
        end

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule